// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point values. Bit 31 is the sign, bits 30..23 the biased exponent (bias 127) and bits 22..0 the fraction, with an implicit leading one. A caller places both operands and the add/subtract select on the inputs and pulses the start input. The block accepts the request only when it is idle. It walks the request through five stages: operand alignment, signed significand addition, normalization, rounding, and a final renormalize-and-classify step. It then presents the packed result together with overflow and underflow flags and a one-cycle completion pulse.

Alignment keeps three bits below the significand: guard, round and a sticky bit that collects every bit shifted out below the round position. Rounding is to nearest with ties going to the even value. If rounding carries out of the significand, the final stage shifts the result back into place and bumps the exponent before the range check. Operands whose exponent field is zero are treated as zero, and results too small for a normal encoding are flushed to zero.

Top module: `sp_fadd_unit`

## Requirements
- R1: For finite, normal or zero operands, the result equals the exact value of a + b, or a − b when the subtract select is 1, rounded to 24 significant bits and packed as sign in bit 31, biased exponent in bits 30..23 and fraction in bits 22..0.
- R2: A start pulse seen while idle is accepted at that clock edge. Busy is high for the following five cycles. The done output is high for exactly one cycle, five edges after acceptance, and the result and flags change only on that edge.
- R3: If the rounded exponent would exceed 254, the result is an infinity with the sign of the sum and the overflow flag is 1. Otherwise the flag is 0.
- R4: If the rounded exponent would fall below 1, the result is a zero that keeps the sign of the sum and the underflow flag is 1. Otherwise the flag is 0.
- R5: When the discarded part is exactly half a unit in the last place, the result is rounded to the neighbour whose lowest fraction bit is 0.
- R6: When rounding carries out of the 24-bit significand, the result is renormalized: fraction 0 and exponent plus one.
- R7: Bits shifted out during alignment below the round position are kept as a sticky bit, so a discarded part just above one half rounds up.
- R8: An exactly zero sum of finite operands, including −0 + −0, gives +0 (0x00000000) with both flags 0.
- R9: A NaN operand (exponent 255, nonzero fraction), or infinities of opposite effective sign, give 0x7FC00000 with both flags 0.
- R10: An infinity combined with a finite value, or with an infinity of the same effective sign, gives that infinity with both flags 0.
- R11: A start pulse while busy is ignored. The running operation finishes with its own operands and no second completion follows.
- R12: During and right after reset, busy and done are 0, the result is 0x00000000 and both flags are 0.
- R13: An operand with exponent field 0 is treated as zero whatever its fraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, honoured only when idle |
| sub_i | input | 1 | 1 selects a − b, 0 selects a + b |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| busy_o | output | 1 | An operation is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 32 | Packed result of the last completed operation |
| ovf_o | output | 1 | Last result overflowed to infinity |
| unf_o | output | 1 | Last result underflowed to zero |

## Verification
The hardest situations to reach are the rounding corners. In these, the guard, round and sticky bits and the lowest kept bit must take one exact combination: a pure tie with an even or an odd last bit, a tie plus a far-away sticky bit, or a round-up that carries out and must be renormalized, possibly into overflow. The stimulus reaches them with operand pairs built so that the exponent difference places the small operand's leading one exactly on the guard bit, with a single extra fraction bit landing well below the round position when the sticky path is wanted. A behavioural model computes each expected result through double-precision arithmetic, whose 53 bits make the later rounding to 24 bits exact. It also tracks busy and done cycle by cycle, so the timing of every operation is compared along with its value.

// File: rtl/sp_fadd_pkg.sv
package sp_fadd_pkg;
  // guard, round and sticky below the kept significand
  localparam int GRS_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ADD,
    ST_NORM,
    ST_RND,
    ST_FIN
  } fadd_state_e;
endpackage

// File: rtl/sp_fadd_align.sv
module sp_fadd_align
  import sp_fadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                          a_sgn,
  input  logic [EXP_W-1:0]              a_exp,
  input  logic [FRAC_W-1:0]             a_frac,
  input  logic                          b_sgn,
  input  logic [EXP_W-1:0]              b_exp,
  input  logic [FRAC_W-1:0]             b_frac,
  output logic                          big_sgn,
  output logic                          small_sgn,
  output logic [EXP_W-1:0]              big_exp,
  output logic [FRAC_W+GRS_W:0]         big_ext,
  output logic [FRAC_W+GRS_W:0]         small_ext
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = SIG_W + GRS_W;

  logic [SIG_W-1:0] a_sig, b_sig, s_sig;
  logic [EXP_W-1:0] s_exp, diff;
  logic [EXT_W-1:0] s_raw, s_shift;
  logic             swap, sticky;

  // exponent field 0 reads as zero (flush)
  assign a_sig = (a_exp == '0) ? '0 : {1'b1, a_frac};
  assign b_sig = (b_exp == '0) ? '0 : {1'b1, b_frac};
  assign swap  = (b_exp > a_exp);

  assign big_sgn   = swap ? b_sgn : a_sgn;
  assign small_sgn = swap ? a_sgn : b_sgn;
  assign big_exp   = swap ? b_exp : a_exp;
  assign s_exp     = swap ? a_exp : b_exp;
  assign s_sig     = swap ? a_sig : b_sig;
  assign big_ext   = {(swap ? b_sig : a_sig), {GRS_W{1'b0}}};
  assign diff      = big_exp - s_exp;
  assign s_raw     = {s_sig, {GRS_W{1'b0}}};

  always_comb begin
    if (diff >= EXP_W'(EXT_W)) begin
      s_shift = '0;
      sticky  = |s_raw;
    end else begin
      s_shift = s_raw >> diff;
      sticky  = |(s_raw & ~({EXT_W{1'b1}} << diff));
    end
    small_ext = {s_shift[EXT_W-1:1], s_shift[0] | sticky};
  end
endmodule

// File: rtl/sp_fadd_norm.sv
module sp_fadd_norm #(
  parameter int EXT_W = 27,
  parameter int XE_W  = 10
) (
  input  logic [EXT_W:0]   mag,
  input  logic [XE_W-1:0]  exp_in,
  output logic [EXT_W-1:0] nrm,
  output logic [XE_W-1:0]  exp_out,
  output logic             is_zero
);
  localparam int LZ_W = $clog2(EXT_W + 1);

  logic [LZ_W-1:0] lz;
  logic            found;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found && mag[i]) begin
        lz    = LZ_W'(EXT_W - 1 - i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    is_zero = (mag == '0);
    if (mag[EXT_W]) begin
      // carry out of the add: one step right, fold the dropped bit into sticky
      nrm     = {mag[EXT_W:2], mag[1] | mag[0]};
      exp_out = exp_in + XE_W'(1);
    end else begin
      nrm     = mag[EXT_W-1:0] << lz;
      exp_out = exp_in - XE_W'(lz);
    end
  end
endmodule

// File: rtl/sp_fadd_round.sv
module sp_fadd_round
  import sp_fadd_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W+GRS_W-1:0] nrm,
  output logic [SIG_W:0]         rnd
);
  logic [SIG_W-1:0] keep;
  logic             guard, tail, up;

  assign keep  = nrm[SIG_W+GRS_W-1:GRS_W];
  assign guard = nrm[GRS_W-1];
  assign tail  = |nrm[GRS_W-2:0];
  assign up    = guard & (tail | keep[0]);
  assign rnd   = {1'b0, keep} + (SIG_W + 1)'(up);
endmodule

// File: rtl/sp_fadd_unit.sv
module sp_fadd_unit
  import sp_fadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        sub_i,
  input  logic [EXP_W+FRAC_W:0]       op_a_i,
  input  logic [EXP_W+FRAC_W:0]       op_b_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [EXP_W+FRAC_W:0]       sum_o,
  output logic                        ovf_o,
  output logic                        unf_o
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = SIG_W + GRS_W;
  localparam int XE_W  = EXP_W + 2;
  localparam logic [EXP_W-1:0] E_ONES = '1;
  localparam logic [W-1:0]     QNAN   = {1'b0, E_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [XE_W-1:0]  XE_TOP = {2'b00, E_ONES};

  fadd_state_e state_q, state_d;

  logic [W-1:0] a_q, b_q;
  logic         sub_q;

  // operand fields and special classes
  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic              a_inf, b_inf, a_nan, b_nan, sp_hit;
  logic [W-1:0]      sp_val;

  assign sa = a_q[W-1];
  assign sb = b_q[W-1] ^ sub_q;
  assign ea = a_q[W-2:FRAC_W];
  assign eb = b_q[W-2:FRAC_W];
  assign fa = a_q[FRAC_W-1:0];
  assign fb = b_q[FRAC_W-1:0];
  assign a_inf = (ea == E_ONES) && (fa == '0);
  assign b_inf = (eb == E_ONES) && (fb == '0);
  assign a_nan = (ea == E_ONES) && (fa != '0);
  assign b_nan = (eb == E_ONES) && (fb != '0);
  assign sp_hit = a_inf | b_inf | a_nan | b_nan;

  always_comb begin
    if (a_nan || b_nan || (a_inf && b_inf && (sa != sb))) sp_val = QNAN;
    else if (a_inf)                                       sp_val = {sa, E_ONES, {FRAC_W{1'b0}}};
    else                                                  sp_val = {sb, E_ONES, {FRAC_W{1'b0}}};
  end

  // stage 1: alignment
  logic                 al_bs_d, al_ss_d;
  logic [EXP_W-1:0]     al_exp_d;
  logic [EXT_W-1:0]     al_big_d, al_small_d;

  sp_fadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) align_i (
    .a_sgn(sa), .a_exp(ea), .a_frac(fa),
    .b_sgn(sb), .b_exp(eb), .b_frac(fb),
    .big_sgn(al_bs_d), .small_sgn(al_ss_d), .big_exp(al_exp_d),
    .big_ext(al_big_d), .small_ext(al_small_d)
  );

  logic                 al_bs_q, al_ss_q, sp_hit_q;
  logic [EXP_W-1:0]     al_exp_q;
  logic [EXT_W-1:0]     al_big_q, al_small_q;
  logic [W-1:0]         sp_val_q;

  // stage 2: signed significand add
  logic [EXT_W:0]       ad_mag_d, ad_mag_q;
  logic                 ad_sgn_d, ad_sgn_q;

  always_comb begin
    if (al_bs_q == al_ss_q) begin
      ad_mag_d = {1'b0, al_big_q} + {1'b0, al_small_q};
      ad_sgn_d = al_bs_q;
    end else if (al_big_q >= al_small_q) begin
      ad_mag_d = {1'b0, al_big_q - al_small_q};
      ad_sgn_d = al_bs_q;
    end else begin
      ad_mag_d = {1'b0, al_small_q - al_big_q};
      ad_sgn_d = al_ss_q;
    end
  end

  // stage 3: normalization
  logic [EXT_W-1:0]     nm_sig_d, nm_sig_q;
  logic [XE_W-1:0]      nm_exp_d, nm_exp_q;
  logic                 nm_zero_d, nm_zero_q;

  sp_fadd_norm #(.EXT_W(EXT_W), .XE_W(XE_W)) norm_i (
    .mag(ad_mag_q), .exp_in({2'b00, al_exp_q}),
    .nrm(nm_sig_d), .exp_out(nm_exp_d), .is_zero(nm_zero_d)
  );

  // stage 4: rounding
  logic [SIG_W:0]       rd_sig_d, rd_sig_q;
  logic [XE_W-1:0]      rd_exp_q;
  logic                 rd_zero_q;

  sp_fadd_round #(.SIG_W(SIG_W)) round_i (.nrm(nm_sig_q), .rnd(rd_sig_d));

  // stage 5: renormalize after rounding and classify the range
  logic [SIG_W-1:0]     fin_sig;
  logic [XE_W-1:0]      fin_exp;
  logic [W-1:0]         res_d;
  logic                 ovf_d, unf_d;

  always_comb begin
    if (rd_sig_q[SIG_W]) begin
      fin_sig = rd_sig_q[SIG_W:1];
      fin_exp = rd_exp_q + XE_W'(1);
    end else begin
      fin_sig = rd_sig_q[SIG_W-1:0];
      fin_exp = rd_exp_q;
    end
    res_d = {ad_sgn_q, fin_exp[EXP_W-1:0], fin_sig[FRAC_W-1:0]};
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (sp_hit_q) begin
      res_d = sp_val_q;
    end else if (rd_zero_q) begin
      res_d = '0;
    end else if ($signed(fin_exp) >= $signed(XE_TOP)) begin
      res_d = {ad_sgn_q, E_ONES, {FRAC_W{1'b0}}};
      ovf_d = 1'b1;
    end else if ($signed(fin_exp) <= $signed(XE_W'(0))) begin
      res_d = {ad_sgn_q, {(W-1){1'b0}}};
      unf_d = 1'b1;
    end
  end

  // sequencing
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ALIGN;
      ST_ALIGN: state_d = ST_ADD;
      ST_ADD:   state_d = ST_NORM;
      ST_NORM:  state_d = ST_RND;
      ST_RND:   state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  logic en_cap, en_al, en_ad, en_nm, en_rd, en_fin;
  assign en_cap = (state_q == ST_IDLE) && start_i;
  assign en_al  = (state_q == ST_ALIGN);
  assign en_ad  = (state_q == ST_ADD);
  assign en_nm  = (state_q == ST_NORM);
  assign en_rd  = (state_q == ST_RND);
  assign en_fin = (state_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      a_q        <= '0;
      b_q        <= '0;
      sub_q      <= 1'b0;
      al_bs_q    <= 1'b0;
      al_ss_q    <= 1'b0;
      al_exp_q   <= '0;
      al_big_q   <= '0;
      al_small_q <= '0;
      sp_hit_q   <= 1'b0;
      sp_val_q   <= '0;
      ad_mag_q   <= '0;
      ad_sgn_q   <= 1'b0;
      nm_sig_q   <= '0;
      nm_exp_q   <= '0;
      nm_zero_q  <= 1'b0;
      rd_sig_q   <= '0;
      rd_exp_q   <= '0;
      rd_zero_q  <= 1'b0;
      sum_o      <= '0;
      ovf_o      <= 1'b0;
      unf_o      <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= en_fin;
      if (en_cap) begin
        a_q   <= op_a_i;
        b_q   <= op_b_i;
        sub_q <= sub_i;
      end
      if (en_al) begin
        al_bs_q    <= al_bs_d;
        al_ss_q    <= al_ss_d;
        al_exp_q   <= al_exp_d;
        al_big_q   <= al_big_d;
        al_small_q <= al_small_d;
        sp_hit_q   <= sp_hit;
        sp_val_q   <= sp_val;
      end
      if (en_ad) begin
        ad_mag_q <= ad_mag_d;
        ad_sgn_q <= ad_sgn_d;
      end
      if (en_nm) begin
        nm_sig_q  <= nm_sig_d;
        nm_exp_q  <= nm_exp_d;
        nm_zero_q <= nm_zero_d;
      end
      if (en_rd) begin
        rd_sig_q  <= rd_sig_d;
        rd_exp_q  <= nm_exp_q;
        rd_zero_q <= nm_zero_q;
      end
      if (en_fin) begin
        sum_o <= res_d;
        ovf_o <= ovf_d;
        unf_o <= unf_d;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/sp_fadd_unit_chk.sv
module sp_fadd_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic [EXP_W+FRAC_W:0]   sum_o,
  input logic                    ovf_o,
  input logic                    unf_o
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(sum_o) && $stable(ovf_o) && $stable(unf_o)));

  assert_ovf_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (sum_o[W-2:0] == INF_MAG));

  assert_flag_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));

  assert_unf_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> (sum_o[W-2:0] == '0));

  assert_nan_canon_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (&sum_o[W-2:FRAC_W]) && (|sum_o[FRAC_W-1:0])) |-> (sum_o == QNAN));
endmodule

bind sp_fadd_unit sp_fadd_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .sum_o(sum_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/sp_fadd_unit_tb_top.sv
`timescale 1ns/1ps
module sp_fadd_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sub = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        busy_o, done_o, ovf_o, unf_o;
  logic [31:0] sum_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    chk_en = 1'b0;
  bit    finished = 1'b0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  sp_fadd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sub_i(sub),
    .op_a_i(op_a), .op_b_i(op_b), .busy_o(busy_o), .done_o(done_o),
    .sum_o(sum_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // ---------------- behavioural reference ----------------
  function automatic real to_real(input logic [31:0] x);
    logic [63:0] d;
    if (x[30:23] == 8'd0) return 0.0;
    d = {x[31], 11'(int'(x[30:23]) + 896), x[22:0], 29'd0};
    return $bitstoreal(d);
  endfunction

  // returns {ovf, unf, result}
  function automatic logic [33:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic        sa, sb, an, bn, ai, bi;
    logic [63:0] d;
    logic [52:0] m;
    logic [24:0] k;
    logic        up;
    real         va, vb, r;
    int          e;
    sa = a[31];
    sb = b[31] ^ s;
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    ai = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bi = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    if (an || bn || (ai && bi && sa != sb)) return {2'b00, 32'h7FC00000};
    if (ai) return {2'b00, sa, 8'hFF, 23'd0};
    if (bi) return {2'b00, sb, 8'hFF, 23'd0};
    va = to_real(a);
    vb = to_real({1'b0, b[30:0]});
    if (sb) vb = -vb;
    r = va + vb;
    if (r == 0.0) return 34'd0;
    d  = $realtobits(r);
    m  = {1'b1, d[51:0]};
    up = m[28] & ((|m[27:0]) | m[29]);
    k  = {1'b0, m[52:29]} + 25'(up);
    e  = int'(d[62:52]) - 896;
    if (k[24]) begin
      k = k >> 1;
      e = e + 1;
    end
    if (e >= 255) return {2'b10, d[63], 8'hFF, 23'd0};
    if (e <= 0)   return {2'b01, d[63], 31'd0};
    return {2'b00, d[63], 8'(e), k[22:0]};
  endfunction

  int          m_cnt;
  logic        m_done, m_ovf, m_unf;
  logic [31:0] m_res;
  logic [33:0] m_pend;
  string       m_tag, p_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  = 0;
      m_done = 1'b0;
      m_res  = '0;
      m_ovf  = 1'b0;
      m_unf  = 1'b0;
      m_tag  = "R12";
    end else begin
      m_done = 1'b0;
      if (m_cnt != 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_done = 1'b1;
          m_ovf  = m_pend[33];
          m_unf  = m_pend[32];
          m_res  = m_pend[31:0];
          m_tag  = p_tag;
        end
      end else if (start) begin
        m_pend = ref_add(op_a, op_b, sub);
        p_tag  = cur_tag;
        m_cnt  = 5;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (chk_en && !finished) begin
      n_cmp++;
      if (busy_o !== (m_cnt != 0) || done_o !== m_done) begin
        n_bad++;
        $display("FAIL R2: busy/done actual %b/%b expected %b/%b", busy_o, done_o, (m_cnt != 0), m_done);
      end else if (sum_o !== m_res || ovf_o !== m_ovf || unf_o !== m_unf) begin
        n_bad++;
        $display("FAIL %s: result/ovf/unf actual %h/%b/%b expected %h/%b/%b",
                 m_tag, sum_o, ovf_o, unf_o, m_res, m_ovf, m_unf);
      end
    end
  end

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic s, input string t);
    @(negedge clk);
    op_a = a; op_b = b; sub = s; cur_tag = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // second start arrives while the first is in flight (R11)
  task automatic run_busy(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] a2, input logic [31:0] b2);
    @(negedge clk);
    op_a = a; op_b = b; sub = 1'b0; cur_tag = "R11"; start = 1'b1;
    @(negedge clk);
    op_a = a2; op_b = b2; sub = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL R2: watchdog expired, actual busy %b expected idle", busy_o);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_en = 1'b1;              // R12 reset state compared from here
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 plain sums and differences
    run(32'h3F000000, 32'hBEE00000, 1'b0, "R1");   // 0.5 + -0.4375
    run(32'hBF400000, 32'hC0A00000, 1'b0, "R1");   // -0.75 + -5.0
    run(32'hC0A00000, 32'hBF400000, 1'b1, "R1");   // -5.0 - -0.75
    run(32'h40490FDB, 32'h402DF854, 1'b0, "R1");
    run(32'h3F800001, 32'h3F800000, 1'b1, "R1");   // heavy cancellation
    run(32'h7F000000, 32'h3F800000, 1'b0, "R1");   // huge exponent gap
    // R5 ties
    run(32'h3F800000, 32'h33800000, 1'b0, "R5");   // tie, even stays
    run(32'h3F800001, 32'h33800000, 1'b0, "R5");   // tie, odd rounds up
    // R6 carry out of rounding
    run(32'h3F7FFFFF, 32'h33000000, 1'b0, "R6");
    // R7 sticky
    run(32'h3F800000, 32'h33800080, 1'b0, "R7");
    run(32'h3F800000, 32'h33800080, 1'b1, "R7");
    // R3 overflow
    run(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R3");
    run(32'h7F7FFFFF, 32'h73000000, 1'b0, "R3");   // rounding pushes over
    run(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, "R3");
    // R4 underflow
    run(32'h00C00000, 32'h00800000, 1'b1, "R4");
    run(32'h80C00000, 32'h00800000, 1'b0, "R4");
    // R8 zero sums
    run(32'h40400000, 32'h40400000, 1'b1, "R8");
    run(32'h80000000, 32'h80000000, 1'b0, "R8");
    run(32'hC0400000, 32'h40400000, 1'b0, "R8");
    // R13 flushed operands
    run(32'h00400000, 32'h3F800000, 1'b0, "R13");
    run(32'h007FFFFF, 32'h00000001, 1'b1, "R13");
    // R9 NaN results
    run(32'h7F800001, 32'h3F800000, 1'b0, "R9");
    run(32'h7F800000, 32'h7F800000, 1'b1, "R9");
    run(32'hFF800000, 32'h7F800000, 1'b0, "R9");
    // R10 infinities
    run(32'h7F800000, 32'hC2000000, 1'b0, "R10");
    run(32'h3F800000, 32'h7F800000, 1'b1, "R10");
    run(32'hFF800000, 32'hFF800000, 1'b0, "R10");
    // R11 start while busy
    run_busy(32'h3F800000, 32'h40000000, 32'h7F800001, 32'h00000000);
    // R2 back-to-back after completion
    run(32'h41200000, 32'hC1A00000, 1'b0, "R2");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule